// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel NOR-style flash device. Once the command sequence for a byte program or an erase has been written, a single `start` pulse hands it the operation kind, a valid address and the expected byte. It then reads that address repeatedly through a one-outstanding request/valid read port. It watches bit 7 of each returned byte, which reads inverted while the device is still working, and bit 5, which the device raises when its internal timer gives up.

A match on bit 7 counts as success. The block then makes one more full-byte read, because the low bits may settle later than bit 7, and presents that byte as the result. A set bit 5 with bit 7 still wrong triggers exactly one re-read before the block gives a verdict, since both bits can flip together. A poll budget, sampled at start, stops the loop if the device never answers. The result is given by a one-cycle `done` pulse and held `pass`/`fail` levels.

Top module: `flash_poll_checker`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `pass`, `fail` and `rd_req` are all 0.
- R2: A `start` seen while idle makes `busy` and `rd_req` go to 1 in the following cycle. `rd_req` is a one-cycle pulse. No new request is issued until `rd_valid` has returned data for the previous one.
- R3: Every read uses the address latched at the accepted start. A `start` pulse while `busy` is 1 is ignored and changes neither the address nor the operation.
- R4: The target level of bit 7 is `exp_data[7]` for a program (`op_erase`=0) and 1 for an erase (`op_erase`=1). A read whose bit 7 differs from the target and whose bit 5 is 0 leads to another poll read.
- R5: A read whose bit 7 equals the target leads to exactly one further read. When that read returns, the operation ends with `pass`=1.
- R6: A read whose bit 7 differs from the target and whose bit 5 is 1 leads to one re-read. If the re-read matches on bit 7, the R5 path follows. Otherwise the operation ends with `fail`=1 and no further read.
- R7: `max_polls` is sampled at start, and 0 counts as 1. If that many consecutive poll reads each show a bit-7 mismatch with bit 5 at 0, the operation ends with `fail`=1 and no further read.
- R8: Each accepted start produces exactly one `done` pulse, one cycle wide, in the cycle after the last read data is taken. In that cycle `busy` is 0 and exactly one of `pass`/`fail` is 1. Both hold until the next accepted start.
- R9: On pass, `result_data` holds the full byte of the final read. It is cleared to 0 at each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (taken only while idle) |
| op_erase | input | 1 | 1 = erase operation, 0 = byte program |
| addr | input | 17 | Valid polling address |
| exp_data | input | 8 | Byte that was programmed |
| max_polls | input | 16 | Poll budget (0 treated as 1) |
| busy | output | 1 | Poll sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last operation succeeded |
| fail | output | 1 | Last operation failed |
| result_data | output | 8 | Settled byte read after success |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 17 | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data |

## Verification
A state register that goes astray shows up at the read port within one read. A missing or extra request changes the number of reads the bench counts for the operation. A request issued while one is still pending is caught at the next request edge. A wrong target bit or mishandled bit-5 path flips the `pass`/`fail` verdict in the `done` cycle. A budget counter that is off by one ends the run one read early or late. A skipped settle read leaves `result_data` holding the unsettled byte, so a wrong value appears in the same `done` cycle.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int STATUS_BIT = 7;
  localparam int TIMEOUT_BIT = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL_REQ,
    S_POLL_WAIT,
    S_RECHK_REQ,
    S_RECHK_WAIT,
    S_DATA_REQ,
    S_DATA_WAIT
  } poll_st_e;
endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/fpc_budget.sv
module fpc_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] limit,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] remain_d;
  logic             remain_en;

  always_comb begin
    remain_en = load || (dec && !last);
    remain_d  = remain_q - ONE;
    if (load) remain_d = (limit == '0) ? ONE : limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= ONE;
    else if (remain_en) remain_q <= remain_d;
  end

  assign last = (remain_q == ONE);

  // R7: the budget never drops to zero, so the final poll is always recognised
  a_r7_budget_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q != '0);
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              budget_last,
  output logic              budget_load,
  output logic              budget_dec,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-1:0] result_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data
);
  poll_st_e st_q, st_d;
  logic     tgt_q;
  logic     start_acc;
  logic     bit_ok;
  logic     pass_evt;
  logic     fail_evt;
  logic     cap_evt;

  assign start_acc = (st_q == S_IDLE) && start;
  assign bit_ok    = (rd_data[STATUS_BIT] == tgt_q);

  always_comb begin
    st_d       = st_q;
    pass_evt   = 1'b0;
    fail_evt   = 1'b0;
    cap_evt    = 1'b0;
    budget_dec = 1'b0;
    unique case (st_q)
      S_IDLE:      if (start) st_d = S_POLL_REQ;
      S_POLL_REQ:  st_d = S_POLL_WAIT;
      S_POLL_WAIT: if (rd_valid) begin
        if (bit_ok) st_d = S_DATA_REQ;
        else if (rd_data[TIMEOUT_BIT]) st_d = S_RECHK_REQ;
        else if (budget_last) begin
          st_d     = S_IDLE;
          fail_evt = 1'b1;
        end else begin
          st_d       = S_POLL_REQ;
          budget_dec = 1'b1;
        end
      end
      S_RECHK_REQ: st_d = S_RECHK_WAIT;
      S_RECHK_WAIT: if (rd_valid) begin
        if (bit_ok) st_d = S_DATA_REQ;
        else begin
          st_d     = S_IDLE;
          fail_evt = 1'b1;
        end
      end
      S_DATA_REQ:  st_d = S_DATA_WAIT;
      S_DATA_WAIT: if (rd_valid) begin
        st_d     = S_IDLE;
        pass_evt = 1'b1;
        cap_evt  = 1'b1;
      end
      default:     st_d = S_IDLE;
    endcase
  end

  assign budget_load = start_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      tgt_q       <= 1'b0;
      rd_addr     <= '0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail        <= 1'b0;
      result_data <= '0;
    end else begin
      st_q <= st_d;
      done <= pass_evt || fail_evt;
      if (start_acc) begin
        tgt_q   <= op_erase ? 1'b1 : exp_data[STATUS_BIT];
        rd_addr <= addr;
      end
      if (start_acc || pass_evt) pass <= pass_evt;
      if (start_acc || fail_evt) fail <= fail_evt;
      if (start_acc || cap_evt) result_data <= cap_evt ? rd_data : '0;
    end
  end

  assign busy   = (st_q != S_IDLE);
  assign rd_req = (st_q == S_POLL_REQ) || (st_q == S_RECHK_REQ) ||
                  (st_q == S_DATA_REQ);

  // R2: a request lasts a single cycle
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R3: the address does not move while an operation runs
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rd_addr == $past(rd_addr)));
  // R8: done is a one-cycle pulse with an exclusive verdict while idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_verdict_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pass ^ fail) && !busy));
  // R5: a pass is only declared on returned read data
  a_r5_pass_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(rd_valid));
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-1:0] result_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data
);
  logic rst_n_sync;
  logic budget_load;
  logic budget_dec;
  logic budget_last;

  fpc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fpc_budget #(.CNT_W(CNT_W)) u_budget (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (budget_load),
    .limit (max_polls),
    .dec   (budget_dec),
    .last  (budget_last)
  );

  fpc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start       (start),
    .op_erase    (op_erase),
    .addr        (addr),
    .exp_data    (exp_data),
    .budget_last (budget_last),
    .budget_load (budget_load),
    .budget_dec  (budget_dec),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .result_data (result_data),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );
endmodule

// File: tb/test_flash_poll_checker.sv
module test_flash_poll_checker;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        op_erase;
  logic [16:0] addr;
  logic [7:0]  exp_data;
  logic [15:0] max_polls;
  logic        busy, done, pass, fail, rd_req;
  logic [7:0]  result_data;
  logic [16:0] rd_addr;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // flash model script
  int          sc_busy;
  int          sc_mode;   // 0 match, 1 flag then match, 2 flag then mismatch
  logic        sc_tgt;
  logic [7:0]  sc_true;
  logic [16:0] exp_addr;
  int          rd_cnt = 0;
  int          addr_err = 0;
  int          overlap_err = 0;
  bit          pending = 0;
  int          lat_left = 0;

  flash_poll_checker i_flash_poll_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .addr(addr), .exp_data(exp_data), .max_polls(max_polls),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .result_data(result_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] resp(input int idx);
    logic [7:0] b;
    b = 8'($urandom);
    if (idx < sc_busy) begin
      b[7] = ~sc_tgt; b[5] = 1'b0;
    end else if (idx == sc_busy) begin
      if (sc_mode == 0) begin
        b[7] = sc_tgt;
        if (b == sc_true) b[0] = ~b[0];
      end else begin
        b[7] = ~sc_tgt; b[5] = 1'b1;
      end
    end else if (idx == sc_busy + 1) begin
      if (sc_mode == 0) b = sc_true;
      else if (sc_mode == 1) b[7] = sc_tgt;
      else b[7] = ~sc_tgt;
    end else begin
      b = sc_true;
    end
    return b;
  endfunction

  always @(negedge clk) begin
    cycles++;
    rd_valid = 1'b0;
    if (pending) begin
      if (lat_left == 0) begin
        rd_valid = 1'b1;
        rd_data  = resp(rd_cnt - 1);
        pending  = 0;
      end else lat_left--;
    end
    if (rst_n && rd_req) begin
      if (pending) overlap_err++;
      if (rd_addr != exp_addr) addr_err++;
      pending  = 1;
      rd_cnt++;
      lat_left = $urandom_range(0, 3);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input bit erase, input logic [16:0] a, input logic [7:0] d,
                        input int maxp, input int nbusy, input int mode,
                        input bit poke_start);
    int eff, exp_reads, t, a0, o0;
    bit exp_pass;
    sc_busy = nbusy; sc_mode = mode;
    sc_tgt  = erase ? 1'b1 : d[7];
    sc_true = erase ? 8'hFF : d;
    if (!erase) sc_true[7] = d[7];
    eff = (maxp == 0) ? 1 : maxp;
    if (nbusy >= eff) begin exp_pass = 0; exp_reads = eff; end
    else if (mode == 0) begin exp_pass = 1; exp_reads = nbusy + 2; end
    else if (mode == 1) begin exp_pass = 1; exp_reads = nbusy + 3; end
    else begin exp_pass = 0; exp_reads = nbusy + 2; end
    a0 = addr_err; o0 = overlap_err;
    exp_addr = a;
    @(negedge clk);
    rd_cnt = 0;
    start = 1'b1; op_erase = erase; addr = a; exp_data = d; max_polls = 16'(maxp);
    @(negedge clk);
    start = 1'b0;
    addr = ~a; exp_data = ~d; op_erase = ~erase;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(rd_req == 1'b1, "R2 request after start", rd_req, 1);
    if (poke_start) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R8 done seen", done, 1);
    chk(busy == 1'b0, "R8 idle at done", busy, 0);
    chk(pass == exp_pass && fail == !exp_pass,
        exp_pass ? "R5 R6 pass verdict" : "R6 R7 fail verdict", {pass, fail}, {exp_pass, !exp_pass});
    chk(rd_cnt == exp_reads, "R4 R7 read count", rd_cnt, exp_reads);
    if (exp_pass) chk(result_data == sc_true, "R9 settled byte", result_data, sc_true);
    else chk(result_data == 8'h00, "R9 cleared on fail", result_data, 0);
    chk(addr_err == a0, "R3 read address", addr_err - a0, 0);
    chk(overlap_err == o0, "R2 one outstanding", overlap_err - o0, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(pass == exp_pass && fail == !exp_pass, "R8 verdict held", {pass, fail}, {exp_pass, !exp_pass});
    chk(rd_cnt == exp_reads && !busy, "R3 ignored start launched nothing", rd_cnt, exp_reads);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; start = 1'b0; op_erase = 1'b0; addr = '0; exp_data = '0;
    max_polls = '0; rd_valid = 1'b0; rd_data = '0; exp_addr = '0;
    sc_busy = 0; sc_mode = 0; sc_tgt = 0; sc_true = 0;
    repeat (3) @(negedge clk);
    chk({busy, done, pass, fail, rd_req} == 5'b0, "R1 in reset", {busy, done, pass, fail, rd_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, pass, fail, rd_req} == 5'b0, "R1 after reset", {busy, done, pass, fail, rd_req}, 0);

    run_op(0, 17'h00123, 8'hA5, 8, 0, 0, 0);     // R5 immediate match, program
    run_op(1, 17'h1F000, 8'h00, 8, 3, 0, 0);     // R4 erase target is 1
    run_op(0, 17'h0BEEF, 8'h3C, 8, 2, 1, 0);     // R6 flag then match
    run_op(0, 17'h05555, 8'h81, 8, 1, 2, 0);     // R6 flag then mismatch
    run_op(1, 17'h0AAAA, 8'h00, 3, 5, 0, 0);     // R7 budget exhausted
    run_op(0, 17'h10001, 8'h7E, 0, 2, 0, 0);     // R7 zero budget acts as one
    run_op(0, 17'h00F0F, 8'h55, 4, 3, 0, 0);     // R7 match on last budgeted poll
    run_op(1, 17'h13579, 8'h00, 10, 2, 1, 1);    // R3 start while busy ignored

    for (int i = 0; i < 40; i++)
      run_op(1'($urandom), 17'($urandom), 8'($urandom), $urandom_range(0, 12),
             $urandom_range(0, 10), $urandom_range(0, 2), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule